// File: doc/BRIEF.md
# NAND Spare-Area Buffer Address Mapper

This block turns a byte transfer request against a NAND page buffer into a stream of buffer-RAM addresses, one byte per clock. A request gives a starting column, a byte count, a direction and a spare-only flag. The page geometry comes with the same request: a page-size code and the spare-area size in bytes. Columns below the page size address the main area, which is laid out contiguously from address 0. Columns at or past the page size address the spare area.

The spare area is spread over eight fixed buffer windows. The page is cut into 512-byte chunks, and each chunk owns the front part of one window. The share per window is the spare size divided by the chunk count, rounded down to an even number. Any bytes left over pile into the last window. The block finds the starting window and the in-window offset with one compare stage, and then walks forward byte by byte. A new burst starts whenever the stream enters another window. When a main-area stream reaches the end of the page, it carries on at spare offset 0.

Each access is presented as a RAM word address with a one-hot byte-lane enable. A single-cycle done pulse follows the last access.

Top module: `nand_spare_mapper`

## Requirements
- R1: After reset, `acc_valid`, `acc_burst_start`, `busy` and `done` are 0.
- R2: The page size is 512 << `page_sel` bytes, with `page_sel` 0..3. The per-window spare share is (`spare_size` >> `page_sel`) with bit 0 cleared.
- R3: A spare offset maps to window index = min(offset / share, 7) and in-window offset = offset − index × share. Its byte address is 0x1000 + index × 0x40 + in-window offset.
- R4: A main-area access uses the column as its byte address. Accesses come one per cycle, in ascending order.
- R5: A main-area stream that reaches the page size continues as a spare stream at spare offset 0.
- R6: With `col_in` ≥ page size, the spare offset is `col_in` − page size. With `spare_only` set and `col_in` < page size, the spare offset is `col_in`. In both cases no main-area access is made.
- R7: Each access drives `acc_word` = byte address >> 2 and `acc_be` with only bit (byte address mod 4) set. `acc_we` equals the `wr_dir` value captured at start.
- R8: `acc_burst_start` is 1 on the first access of a request. It is also 1 on each access that enters a different buffer (main area or spare window) from the access before it. It is 0 otherwise.
- R9: The first access appears the cycle after an accepted `start`. `done` is a one-cycle pulse in the cycle after the last access, with `acc_valid` low during that cycle. `busy` is high from the cycle after start through the done cycle.
- R10: A request with `len_in` = 0 makes no access and pulses `done` in the cycle after `start`.
- R11: `start` is ignored while `busy` is high. The ongoing stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| page_sel | input | 2 | Page size code: 512 << page_sel bytes |
| spare_size | input | 8 | Spare-area size in bytes |
| col_in | input | 13 | Starting column |
| len_in | input | 13 | Byte count |
| spare_only | input | 1 | Map the column straight to the spare area |
| wr_dir | input | 1 | Direction: 1 write, 0 read |
| acc_valid | output | 1 | An access is presented this cycle |
| acc_we | output | 1 | Access direction |
| acc_word | output | 11 | Buffer RAM word address |
| acc_be | output | 4 | One-hot byte-lane enable |
| acc_burst_start | output | 1 | First access of a new burst |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |

## Verification
Suppose the window index, the in-window offset or the main/spare flag goes wrong. That error appears in `acc_word`/`acc_be` on the very access where it happens, and every later byte of the request inherits it. The bench therefore compares every byte of every request against an arithmetic model that uses division. A remaining-count error appears as a `done` pulse one or more cycles early or late, and as extra or missing `acc_valid` cycles. A lost window crossing shows up as a missing `acc_burst_start`, or as an address that keeps climbing past the share.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
    localparam int NSM_NBUF       = 8;
    localparam int NSM_STRIDE     = 64;
    localparam int NSM_SPARE_BASE = 4096;
    localparam int NSM_CHUNK      = 512;
    localparam int NSM_LANES      = 4;
    localparam int NSM_COL_W      = 13;
    localparam int NSM_LEN_W      = 13;
    localparam int NSM_SPARE_W    = 8;
    localparam int NSM_ADDR_W     = 13;
    localparam int NSM_IDX_W      = $clog2(NSM_NBUF);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } nsm_state_e;

    typedef struct packed {
        logic                   in_main;
        logic                   first;
        logic [NSM_COL_W-1:0]   col;
        logic [NSM_IDX_W-1:0]   idx;
        logic [NSM_SPARE_W-1:0] boff;
    } nsm_cursor_t;

    // even per-window share: spare bytes per 512-byte chunk, bit 0 dropped
    function automatic logic [NSM_SPARE_W-1:0] share_of(
        input logic [NSM_SPARE_W-1:0] spare, input logic [1:0] psel);
        logic [NSM_SPARE_W-1:0] q;
        q = spare >> psel;
        q[0] = 1'b0;
        return q;
    endfunction
endpackage

// File: rtl/nsm_geom.sv
module nsm_geom
    import nsm_pkg::*;
#(
    parameter int COL_W   = NSM_COL_W,
    parameter int SPARE_W = NSM_SPARE_W,
    parameter int CHUNK   = NSM_CHUNK
) (
    input  logic [1:0]         page_sel,
    input  logic [SPARE_W-1:0] spare_size,
    output logic [COL_W-1:0]   page_bytes,
    output logic [SPARE_W-1:0] share
);
    localparam logic [COL_W-1:0] CHUNK_C = COL_W'(CHUNK);

    always_comb begin
        page_bytes = CHUNK_C << page_sel;
        share      = SPARE_W'(share_of(NSM_SPARE_W'(spare_size), page_sel));
    end
endmodule

// File: rtl/nsm_locate.sv
module nsm_locate
    import nsm_pkg::*;
#(
    parameter int COL_W   = NSM_COL_W,
    parameter int SPARE_W = NSM_SPARE_W,
    parameter int NBUF    = NSM_NBUF
) (
    input  logic [COL_W-1:0]        off,
    input  logic [SPARE_W-1:0]      share,
    output logic [$clog2(NBUF)-1:0] idx,
    output logic [SPARE_W-1:0]      boff
);
    localparam int IDX_W = $clog2(NBUF);
    localparam int WW    = COL_W + IDX_W + 1;

    logic [NBUF-2:0] past_thr;

    // one compare per window boundary; thresholds rise, so the count of
    // boundaries passed is the index, capped at NBUF-1 by construction
    for (genvar n = 1; n < NBUF; n++) begin : g_thr
        logic [WW-1:0] thr;
        assign thr = WW'(n) * WW'(share);
        assign past_thr[n-1] = WW'(off) >= thr;
    end

    logic [WW-1:0] base;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NBUF - 1; i++) begin
            idx = idx + IDX_W'(past_thr[i]);
        end
        base = WW'(idx) * WW'(share);
        boff = SPARE_W'(WW'(off) - base);
    end
endmodule

// File: rtl/nsm_lane.sv
module nsm_lane #(
    parameter int ADDR_W = 13,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0]                    byte_addr,
    input  logic                                 en,
    output logic [ADDR_W-$clog2(LANES)-1:0]      word,
    output logic [LANES-1:0]                     be
);
    localparam int LW = $clog2(LANES);

    assign word = byte_addr[ADDR_W-1:LW];

    for (genvar l = 0; l < LANES; l++) begin : g_be
        assign be[l] = en && (byte_addr[LW-1:0] == LW'(l));
    end
endmodule

// File: rtl/nand_spare_mapper.sv
module nand_spare_mapper
    import nsm_pkg::*;
#(
    parameter int NBUF       = NSM_NBUF,
    parameter int STRIDE     = NSM_STRIDE,
    parameter int SPARE_BASE = NSM_SPARE_BASE,
    parameter int CHUNK      = NSM_CHUNK,
    parameter int LANES      = NSM_LANES,
    parameter int COL_W      = NSM_COL_W,
    parameter int LEN_W      = NSM_LEN_W,
    parameter int SPARE_W    = NSM_SPARE_W,
    parameter int ADDR_W     = NSM_ADDR_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic [1:0]                        page_sel,
    input  logic [SPARE_W-1:0]                spare_size,
    input  logic [COL_W-1:0]                  col_in,
    input  logic [LEN_W-1:0]                  len_in,
    input  logic                              spare_only,
    input  logic                              wr_dir,
    output logic                              acc_valid,
    output logic                              acc_we,
    output logic [ADDR_W-$clog2(LANES)-1:0]   acc_word,
    output logic [LANES-1:0]                  acc_be,
    output logic                              acc_burst_start,
    output logic                              busy,
    output logic                              done
);
    localparam int IDX_W = $clog2(NBUF);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBUF - 1);

    nsm_state_e             state;
    nsm_cursor_t            cur;
    logic [LEN_W-1:0]       rem;
    logic [COL_W-1:0]       page_q;
    logic [SPARE_W-1:0]     share_q;
    logic                   we_q;

    // geometry of the incoming request
    logic [COL_W-1:0]       page_in;
    logic [SPARE_W-1:0]     share_in;

    nsm_geom #(.COL_W(COL_W), .SPARE_W(SPARE_W), .CHUNK(CHUNK)) u_geom (
        .page_sel   (page_sel),
        .spare_size (spare_size),
        .page_bytes (page_in),
        .share      (share_in)
    );

    // starting window of a request that begins in the spare area
    logic                   go_main;
    logic [COL_W-1:0]       spare_off0;
    logic [IDX_W-1:0]       idx0;
    logic [SPARE_W-1:0]     boff0;

    always_comb begin
        go_main    = !spare_only && (col_in < page_in);
        spare_off0 = (col_in >= page_in) ? (col_in - page_in) : col_in;
    end

    nsm_locate #(.COL_W(COL_W), .SPARE_W(SPARE_W), .NBUF(NBUF)) u_loc (
        .off   (spare_off0),
        .share (share_in),
        .idx   (idx0),
        .boff  (boff0)
    );

    // cursor advance for one streamed byte
    nsm_cursor_t            cur_nx;
    logic [COL_W-1:0]       col_inc;
    logic [SPARE_W-1:0]     boff_inc;

    always_comb begin
        col_inc  = cur.col + 1'b1;
        boff_inc = cur.boff + 1'b1;
        cur_nx   = cur;
        cur_nx.col   = col_inc;
        cur_nx.first = 1'b0;
        if (cur.in_main) begin
            if (col_inc == page_q) begin
                cur_nx.in_main = 1'b0;
                cur_nx.idx     = '0;
                cur_nx.boff    = '0;
                cur_nx.first   = 1'b1;
            end
        end else if (cur.idx != LAST_IDX && boff_inc == share_q) begin
            cur_nx.idx   = cur.idx + 1'b1;
            cur_nx.boff  = '0;
            cur_nx.first = 1'b1;
        end else begin
            cur_nx.boff = boff_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur     <= '0;
            rem     <= '0;
            page_q  <= '0;
            share_q <= '0;
            we_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        page_q       <= page_in;
                        share_q      <= share_in;
                        we_q         <= wr_dir;
                        rem          <= len_in;
                        cur.in_main  <= go_main;
                        cur.first    <= 1'b1;
                        cur.col      <= col_in;
                        cur.idx      <= go_main ? '0 : idx0;
                        cur.boff     <= go_main ? '0 : boff0;
                        state        <= (len_in == '0) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    cur <= cur_nx;
                    rem <= rem - 1'b1;
                    if (rem == LEN_W'(1)) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // byte address of the current access
    logic [ADDR_W-1:0] byte_addr;

    always_comb begin
        if (cur.in_main) begin
            byte_addr = ADDR_W'(cur.col);
        end else begin
            byte_addr = ADDR_W'(SPARE_BASE) + ADDR_W'(cur.idx) * ADDR_W'(STRIDE)
                      + ADDR_W'(cur.boff);
        end
    end

    assign acc_valid       = (state == ST_RUN);
    assign acc_we          = acc_valid && we_q;
    assign acc_burst_start = acc_valid && cur.first;
    assign busy            = (state != ST_IDLE);
    assign done            = (state == ST_DONE);

    nsm_lane #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lane (
        .byte_addr (byte_addr),
        .en        (acc_valid),
        .word      (acc_word),
        .be        (acc_be)
    );
endmodule

// File: rtl/nsm_checker.sv
module nsm_checker #(
    parameter int ADDR_W = 13,
    parameter int LANES  = 4,
    parameter int LEN_W  = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [LEN_W-1:0]  len_in,
    input logic              acc_valid,
    input logic [LANES-1:0]  acc_be,
    input logic              acc_burst_start,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] byte_addr
);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !acc_valid);

    a_r7_be_single: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> $countones(acc_be) == 1);

    a_r8_first_burst: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !$past(acc_valid)) |-> acc_burst_start);

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && $past(acc_valid) && !acc_burst_start)
            |-> byte_addr == $past(byte_addr) + 1'b1);

    a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && len_in == '0) |=> (done && !acc_valid));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

bind nand_spare_mapper nsm_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LEN_W  (LEN_W)
) u_nsm_checker (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .len_in          (len_in),
    .acc_valid       (acc_valid),
    .acc_be          (acc_be),
    .acc_burst_start (acc_burst_start),
    .busy            (busy),
    .done            (done),
    .byte_addr       (byte_addr)
);

// File: tb/nand_spare_mapper_bench.sv
module nand_spare_mapper_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  page_sel;
    logic [7:0]  spare_size;
    logic [12:0] col_in;
    logic [12:0] len_in;
    logic        spare_only;
    logic        wr_dir;
    logic        acc_valid;
    logic        acc_we;
    logic [10:0] acc_word;
    logic [3:0]  acc_be;
    logic        acc_burst_start;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_spare_mapper u_nand_spare_mapper (
        .clk (clk), .rst (rst), .start (start), .page_sel (page_sel),
        .spare_size (spare_size), .col_in (col_in), .len_in (len_in),
        .spare_only (spare_only), .wr_dir (wr_dir), .acc_valid (acc_valid),
        .acc_we (acc_we), .acc_word (acc_word), .acc_be (acc_be),
        .acc_burst_start (acc_burst_start), .busy (busy), .done (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model: region -1 for main area, else spare window index
    function automatic int ref_addr(input int pg, input int sp, input int col,
                                    input bit so, input int k, output int region);
        int page, sb, off, idx;
        page = 512 << pg;
        sb   = (sp >> pg) & ~1;
        if (!so && col < page) begin
            if (col + k < page) begin
                region = -1;
                return col + k;
            end
            off = col + k - page;
        end else begin
            off = ((col >= page) ? col - page : col) + k;
        end
        idx = off / sb;
        if (idx > 7) idx = 7;
        region = idx;
        return 4096 + idx * 64 + off - idx * sb;
    endfunction

    task automatic run(input int pg, input int sp, input int col, input int len,
                       input bit so, input bit we, input bit poke);
        int a, reg_k, reg_prev;
        string tag;
        @(negedge clk);
        page_sel = 2'(pg); spare_size = 8'(sp); col_in = 13'(col);
        len_in = 13'(len); spare_only = so; wr_dir = we; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        reg_prev = -2;
        for (int k = 0; k < len; k++) begin
            a = ref_addr(pg, sp, col, so, k, reg_k);
            if (reg_k < 0) tag = "R4 main addr";
            else if (!so && col < 512 << pg) tag = "R5/R2/R3 crossed spare addr";
            else tag = "R6/R2/R3 direct spare addr";
            chk(acc_valid == 1'b1, "R9 valid during stream", int'(acc_valid), 1);
            chk(acc_word == 11'(a >> 2), tag, int'(acc_word), a >> 2);
            chk(acc_be == 4'(1 << (a % 4)), "R7 byte enable", int'(acc_be), 1 << (a % 4));
            chk(acc_we == we, "R7 direction", int'(acc_we), int'(we));
            chk(acc_burst_start == (reg_k != reg_prev), "R8 burst start",
                int'(acc_burst_start), int'(reg_k != reg_prev));
            reg_prev = reg_k;
            if (poke && k == 1) begin
                // R11: a start while busy must not disturb the stream
                start = 1'b1; col_in = 13'(col + 100); len_in = 13'd2;
                spare_only = ~so;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b1, len == 0 ? "R10 zero-length done" : "R9 done after last",
            int'(done), 1);
        chk(acc_valid == 1'b0, "R9 no access with done", int'(acc_valid), 0);
        chk(busy == 1'b1, "R9 busy in done cycle", int'(busy), 1);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
        chk(busy == 1'b0, poke ? "R11 idle after stream" : "R9 idle after done",
            int'(busy), 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; page_sel = '0; spare_size = '0; col_in = '0;
        len_in = '0; spare_only = 1'b0; wr_dir = 1'b0;
        repeat (3) @(negedge clk);
        chk(acc_valid == 1'b0 && busy == 1'b0 && done == 1'b0 && acc_burst_start == 1'b0,
            "R1 reset state", int'({acc_valid, busy, done, acc_burst_start}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);

        for (int pg = 0; pg < 4; pg++) begin
            for (int si = 0; si < 3; si++) begin
                int sp, page, sb;
                sp   = (si == 0) ? 16 : (si == 1) ? 27 : 64;
                page = 512 << pg;
                sb   = (sp >> pg) & ~1;
                for (int ci = 0; ci < 6; ci++) begin
                    int col;
                    bit so;
                    so  = (ci == 5);
                    col = (ci == 0) ? 0 : (ci == 1) ? page - 3 : (ci == 2) ? page :
                          (ci == 3) ? page + sb - 1 : (ci == 4) ? page + 7 * sb - 1 : 5;
                    for (int li = 0; li < 4; li++) begin
                        int len;
                        len = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 9 : 40;
                        run(pg, sp, col, len, so, bit'((li + ci) % 2), 1'b0);
                    end
                end
            end
        end
        // large uneven spare: share 26, remainder lands in window 7
        run(3, 218, 4096 + 7 * 26 - 2, 40, 1'b0, 1'b1, 1'b0);
        run(3, 218, 4090, 30, 1'b0, 1'b0, 1'b0);
        // start while busy
        run(1, 64, 1020, 12, 1'b0, 1'b1, 1'b1);
        run(2, 27, 3, 20, 1'b1, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule